// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block derives the bit timing of a CAN node from the peripheral clock. A baud prescaler divides the clock into time quanta. Each bit is made of one synchronization quantum, a first phase segment and a second phase segment, and the lengths of the two phase segments are set separately in quanta. The unit reports the quantum tick, the sample point strobe at the end of the first phase segment and the transmit point strobe at the start of each bit. It also latches the received bit at the sample point.

The phase of the bit counter follows the bus. While the frame logic reports an idle bus, any recessive-to-dominant transition restarts the bit (hard synchronization). Inside a frame, one such transition per bit moves the phase instead: a late edge lengthens the first segment and an early edge shortens the second one, by no more than the programmed jump width. One 32-bit configuration word holds the timing fields and two test-mode bits. In loopback mode the receive path is fed from the transmit output. In silent mode the transmit output stays recessive.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration word resets to zero. Only bits 31, 30, 25:24, 22:20, 19:16 and 9:0 are stored, and every other bit reads back as zero whatever was written to it.
- R2: `tq_tick` pulses for one cycle once every (Q+1) clock cycles, where Q is the value of config bits 9:0.
- R3: With no bus edges, a bit lasts 1 + (A+1) + (B+1) quanta, where A is config bits 19:16 and B is config bits 22:20.
- R4: `sample_pt` is asserted on the tick that ends the first phase segment, (A+2) quanta after the `tx_pt` that started the bit. `tx_pt` is asserted on the tick that enters the synchronization quantum.
- R5: While `bus_idle` is 1, a recessive-to-dominant edge sampled on a tick makes the next quantum the first quantum of phase segment 1. That tick carries neither strobe.
- R6: An edge in phase segment 1 at quantum position p (the synchronization quantum is position 0) lengthens that segment by min(p, J+1) quanta, where J is config bits 25:24.
- R7: An edge in phase segment 2 with r quanta left, counting the current one, shortens that segment by J+1 when r > J+1. Otherwise the bit restarts as in R5, without either strobe on that tick.
- R8: At most one phase adjustment is made per bit, an edge in the synchronization quantum uses that bit's adjustment without moving the phase, and dominant-to-recessive edges have no effect.
- R9: When config bit 30 is 1, the receive path uses `tx_pin` and ignores `rx_pin`. `loopback_mode` shows bit 30.
- R10: When config bit 31 is 1, `tx_pin` is 1 (recessive). Otherwise it follows `tx_bit`. `silent_mode` shows bit 31.
- R11: `rx_bit` resets to 1. It takes the received level seen at each sample point in the cycle after `sample_pt`, and it holds that value at all other times.
- R12: `sample_pt` and `tx_pt` are only asserted together with `tq_tick`, and never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Writes `cfg_wr_data` into the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Stored configuration word |
| bus_idle | input | 1 | Frame logic reports an idle bus, which enables hard synchronization |
| rx_pin | input | 1 | Bus receive level, already synchronized to `clk` |
| tx_bit | input | 1 | Bit the controller wants to send |
| tx_pin | output | 1 | Bus transmit level |
| rx_bit | output | 1 | Bit value taken at the last sample point |
| tq_tick | output | 1 | One-cycle pulse per time quantum |
| sample_pt | output | 1 | Sample point strobe |
| tx_pt | output | 1 | Start-of-bit transmit strobe |
| silent_mode | output | 1 | Silent mode control |
| loopback_mode | output | 1 | Loopback mode control |

## Verification
The assertions assume that `rx_pin`, `tx_bit` and `bus_idle` are already synchronous to `clk`, and that the configuration is written only with `cfg_wr_en`. The tick-spacing property is waived in any cycle where a write may change the prescaler. The bench changes inputs only just after a rising edge. After every configuration write it holds the bus recessive and idle, then forces a hard synchronization before any phase is checked. This means the bit position is always known and never inherited from an earlier timing setup. Random edges are applied only while `bus_idle` is low, so every edge exercises resynchronization rather than a restart.

// File: rtl/can_bt_pkg.sv
// Shared field layout, types and widths of the CAN bit timing unit.
// Assumes a 32-bit configuration word. The field positions are fixed
// because the surrounding controller decodes the same word.
package can_bt_pkg;
    localparam int CFG_W      = 32;
    localparam int BRP_W      = 10;
    localparam int TS1_W      = 4;
    localparam int TS2_W      = 3;
    localparam int SJW_W      = 2;
    localparam int BRP_LSB    = 0;
    localparam int TS1_LSB    = 16;
    localparam int TS2_LSB    = 20;
    localparam int SJW_LSB    = 24;
    localparam int LOOP_BIT   = 30;
    localparam int SILENT_BIT = 31;
    // quantum counter must hold segment 1 plus the largest extension
    localparam int QC_W       = TS1_W + 2;
    localparam logic [CFG_W-1:0] CFG_MASK = 32'hC37F_03FF;

    typedef struct packed {
        logic             silent;
        logic             loopback;
        logic [SJW_W-1:0] sjw;
        logic [TS2_W-1:0] ts2;
        logic [TS1_W-1:0] ts1;
        logic [BRP_W-1:0] brp;
    } bt_cfg_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } bt_seg_e;
endpackage

// File: rtl/can_bt_cfg_reg.sv
// Configuration word storage. Reserved bits are masked off on write, so
// they always read back as zero. Assumes writes come from a synchronous
// register bus.
module can_bt_cfg_reg
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output bt_cfg_t          cfg
);
    logic [CFG_W-1:0] word_q;

    // store only the defined fields
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (wr_en)
            word_q <= wr_data & CFG_MASK;
    end

    assign rd_data      = word_q;
    assign cfg.brp      = word_q[BRP_LSB +: BRP_W];
    assign cfg.ts1      = word_q[TS1_LSB +: TS1_W];
    assign cfg.ts2      = word_q[TS2_LSB +: TS2_W];
    assign cfg.sjw      = word_q[SJW_LSB +: SJW_W];
    assign cfg.loopback = word_q[LOOP_BIT];
    assign cfg.silent   = word_q[SILENT_BIT];
endmodule

// File: rtl/can_bt_prescaler.sv
// Time-quantum prescaler. It emits one tick every (brp+1) clocks.
// A count left above a newly lowered limit ends at once, so the
// prescaler cannot hang after a reprogramming.
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    logic [BRP_W-1:0] cnt_q;

    assign tick = (cnt_q >= brp);

    // count clocks inside the current quantum
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + BRP_W'(1);
    end
endmodule

// File: rtl/can_bt_seq.sv
// Bit segment sequencer. It steps through sync, phase 1 and phase 2 on each
// quantum tick. It makes one phase correction per bit from a falling edge
// of the received level, and restarts the bit on an edge while the bus is idle.
// Assumes rx_in is synchronous to clk. Edges are sampled at quantum rate.
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [TS1_W-1:0] ts1,
    input  logic [TS2_W-1:0] ts2,
    input  logic [SJW_W-1:0] sjw,
    input  logic             bus_idle,
    input  logic             rx_in,
    output logic             sample_pt,
    output logic             tx_pt
);
    bt_seg_e         seg_q;
    logic [QC_W-1:0] qcnt_q, ext_q, shr_q;
    logic            done_q, prev_rx_q;

    logic            edge_fall, hard, resync, jump, bit_end;
    logic [QC_W-1:0] len1_base, len2_base, sjwq, qinc;
    logic [QC_W-1:0] ext_add, len1_eff, len2_cur, rem2, shr_nxt, len2_eff;

    // phase error, correction and segment end decisions for this tick
    always_comb begin
        edge_fall = prev_rx_q & ~rx_in;
        hard      = tick & edge_fall & bus_idle;
        resync    = tick & edge_fall & ~bus_idle & ~done_q;
        len1_base = QC_W'(ts1) + QC_W'(1);
        len2_base = QC_W'(ts2) + QC_W'(1);
        sjwq      = QC_W'(sjw) + QC_W'(1);
        qinc      = qcnt_q + QC_W'(1);
        ext_add   = (qinc < sjwq) ? qinc : sjwq;
        len1_eff  = len1_base + ext_q +
                    ((resync && seg_q == SEG_ONE) ? ext_add : '0);
        len2_cur  = len2_base - shr_q;
        rem2      = (qcnt_q < len2_cur) ? (len2_cur - qcnt_q) : QC_W'(1);
        jump      = resync && (seg_q == SEG_TWO) && (rem2 <= sjwq);
        shr_nxt   = (resync && seg_q == SEG_TWO && !jump) ? sjwq : shr_q;
        len2_eff  = len2_base - shr_nxt;
        bit_end   = (seg_q == SEG_TWO) && (qinc >= len2_eff);
        sample_pt = tick && !hard && !jump && (seg_q == SEG_ONE) &&
                    (qinc >= len1_eff);
        tx_pt     = tick && !hard && !jump && bit_end;
    end

    // advance the segment state once per quantum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q     <= SEG_SYNC;
            qcnt_q    <= '0;
            ext_q     <= '0;
            shr_q     <= '0;
            done_q    <= 1'b0;
            prev_rx_q <= 1'b1;
        end else if (tick) begin
            prev_rx_q <= rx_in;
            if (hard || jump) begin
                seg_q  <= SEG_ONE;
                qcnt_q <= '0;
                ext_q  <= '0;
                shr_q  <= '0;
                done_q <= 1'b1;
            end else begin
                case (seg_q)
                    SEG_SYNC: begin
                        seg_q  <= SEG_ONE;
                        qcnt_q <= '0;
                        done_q <= done_q | resync;
                    end
                    SEG_ONE: begin
                        done_q <= done_q | resync;
                        if (qinc >= len1_eff) begin
                            seg_q  <= SEG_TWO;
                            qcnt_q <= '0;
                        end else begin
                            qcnt_q <= qinc;
                            ext_q  <= len1_eff - len1_base;
                        end
                    end
                    SEG_TWO: begin
                        if (bit_end) begin
                            seg_q  <= SEG_SYNC;
                            qcnt_q <= '0;
                            ext_q  <= '0;
                            shr_q  <= '0;
                            done_q <= 1'b0;
                        end else begin
                            qcnt_q <= qinc;
                            shr_q  <= shr_nxt;
                            done_q <= done_q | resync;
                        end
                    end
                    default: begin
                        seg_q  <= SEG_SYNC;
                        qcnt_q <= '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
// Top of the CAN bit timing unit. It joins the configuration word, the
// prescaler and the segment sequencer. It applies the loopback and silent
// paths and latches the received bit at each sample point.
// Assumes rx_pin and bus_idle are synchronous to clk.
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        bus_idle,
    input  logic        rx_pin,
    input  logic        tx_bit,
    output logic        tx_pin,
    output logic        rx_bit,
    output logic        tq_tick,
    output logic        sample_pt,
    output logic        tx_pt,
    output logic        silent_mode,
    output logic        loopback_mode
);
    bt_cfg_t cfg;
    logic    rx_eff;

    can_bt_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .cfg     (cfg)
    );

    can_bt_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .brp   (cfg.brp),
        .tick  (tq_tick)
    );

    // silent forces recessive out; loopback feeds the output back in
    assign tx_pin = cfg.silent ? 1'b1 : tx_bit;
    assign rx_eff = cfg.loopback ? tx_pin : rx_pin;

    can_bt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tq_tick),
        .ts1       (cfg.ts1),
        .ts2       (cfg.ts2),
        .sjw       (cfg.sjw),
        .bus_idle  (bus_idle),
        .rx_in     (rx_eff),
        .sample_pt (sample_pt),
        .tx_pt     (tx_pt)
    );

    // hold the level seen at the last sample point
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_bit <= 1'b1;
        else if (sample_pt)
            rx_bit <= rx_eff;
    end

    assign silent_mode   = cfg.silent;
    assign loopback_mode = cfg.loopback;
endmodule

// File: rtl/can_bit_timer_chk.sv
// Assertion checker for can_bit_timer, attached with bind.
// Assumes the inputs are synchronous to clk.
module can_bit_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_rd_data,
    input logic        tx_pin,
    input logic        rx_bit,
    input logic        tq_tick,
    input logic        sample_pt,
    input logic        tx_pt,
    input logic        silent_mode,
    input logic        loopback_mode
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data & ~32'hC37F_03FF) == 32'h0);

    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && cfg_rd_data[9:0] != 10'd0 && !cfg_wr_en) |=> !tq_tick);

    a_r9_loop_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback_mode && sample_pt) |=> (rx_bit == $past(tx_pin)));

    a_r10_silent_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        silent_mode |-> tx_pin);

    a_r11_rx_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_pt |=> $stable(rx_bit));

    a_r12_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> tq_tick);

    a_r12_tx_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pt |-> tq_tick);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_pt, tx_pt}));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_rd_data   (cfg_rd_data),
    .tx_pin        (tx_pin),
    .rx_bit        (rx_bit),
    .tq_tick       (tq_tick),
    .sample_pt     (sample_pt),
    .tx_pt         (tx_pt),
    .silent_mode   (silent_mode),
    .loopback_mode (loopback_mode)
);

// File: tb/can_bit_timer_tb.sv
// Self-checking bench for can_bit_timer. It uses seeded random bus edges
// plus directed timing setups, with a per-quantum reference model
// written from the requirements.
module can_bit_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        bus_idle = 1'b1;
    logic        rx_pin = 1'b1;
    logic        tx_bit = 1'b1;
    wire  [31:0] cfg_rd_data;
    wire         tx_pin, rx_bit, tq_tick, sample_pt, tx_pt;
    wire         silent_mode, loopback_mode;

    always #4 clk = ~clk;

    can_bit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .bus_idle(bus_idle), .rx_pin(rx_pin),
        .tx_bit(tx_bit), .tx_pin(tx_pin), .rx_bit(rx_bit), .tq_tick(tq_tick),
        .sample_pt(sample_pt), .tx_pt(tx_pt), .silent_mode(silent_mode),
        .loopback_mode(loopback_mode)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int wd = 0;

    int c_brp = 0, c_ts1 = 0, c_ts2 = 0, c_sjw = 0;
    bit c_lb = 1'b0, c_sil = 1'b0;

    bit    m_valid = 1'b0, m_done = 1'b0, m_prev = 1'b1;
    int    m_pos = 0, m_ext = 0, m_shr = 0;
    string m_tag = "R3";
    bit    exp_rx_pend = 1'b0, exp_rx = 1'b1;
    bit    tick_seen = 1'b0, tx_seen = 1'b0;
    int    cyc_tick = 0, cyc_tx = 0;
    bit    rxv, txe, fall, es, et, jumped;
    int    t1, t2, sq, rem;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // reference model and per-cycle checks, run away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            txe = c_sil ? 1'b1 : tx_bit;
            rxv = c_lb ? txe : rx_pin;
            chk(tx_pin == txe, "R10", "tx_pin", tx_pin, txe);
            if (exp_rx_pend) begin
                chk(rx_bit == exp_rx, c_lb ? "R9" : "R11", "rx_bit", rx_bit, exp_rx);
                exp_rx_pend = 1'b0;
            end
            cyc_tick++;
            cyc_tx++;
            if (!tq_tick) begin
                chk(!sample_pt && !tx_pt, "R12", "strobe off tick",
                    {sample_pt, tx_pt}, 0);
            end else begin
                if (tick_seen) chk(cyc_tick == c_brp + 1, "R2", "tick gap", cyc_tick, c_brp + 1);
                tick_seen = 1'b1;
                cyc_tick = 0;
                fall = m_prev && !rxv;
                m_prev = rxv;
                es = 1'b0; et = 1'b0; jumped = 1'b0;
                sq = c_sjw + 1;
                if (fall && bus_idle) begin
                    m_valid = 1'b1; m_pos = 1; m_ext = 0; m_shr = 0; m_done = 1'b1;
                    m_tag = "R5"; jumped = 1'b1;
                end else if (m_valid) begin
                    t1 = c_ts1 + 1 + m_ext;
                    t2 = c_ts2 + 1 - m_shr;
                    if (fall && !m_done) begin
                        m_done = 1'b1;
                        if (m_pos == 0) begin
                            m_tag = "R8";
                        end else if (m_pos <= t1) begin
                            m_ext = m_ext + min2(m_pos, sq);
                            m_tag = "R6";
                        end else begin
                            rem = t1 + t2 - m_pos + 1;
                            m_tag = "R7";
                            if (rem <= sq) begin
                                m_pos = 1; m_ext = 0; m_shr = 0; jumped = 1'b1;
                            end else begin
                                m_shr = sq;
                            end
                        end
                    end else if (fall) begin
                        m_tag = "R8";
                    end
                    if (!jumped) begin
                        t1 = c_ts1 + 1 + m_ext;
                        t2 = c_ts2 + 1 - m_shr;
                        es = (m_pos == t1);
                        et = (m_pos == t1 + t2);
                        if (et) begin
                            m_pos = 0; m_ext = 0; m_shr = 0; m_done = 1'b0;
                        end else begin
                            m_pos++;
                        end
                    end
                end
                if (m_valid) begin
                    chk(sample_pt == es, m_tag, "sample_pt", sample_pt, es);
                    chk(tx_pt == et, m_tag, "tx_pt", tx_pt, et);
                    if (es) begin
                        exp_rx = rxv;
                        exp_rx_pend = 1'b1;
                        if (tx_seen && m_tag == "R3")
                            chk(cyc_tx == (c_ts1 + 2) * (c_brp + 1), "R4", "tx to sample",
                                cyc_tx, (c_ts1 + 2) * (c_brp + 1));
                    end
                    if (et) begin
                        cyc_tx = 0;
                        tx_seen = 1'b1;
                        m_tag = c_lb ? "R9" : "R3";
                    end
                end
            end
        end
    end

    task automatic write_cfg(input int brp, input int ts1, input int ts2, input int sjw,
                             input bit lb, input bit sil);
        logic [31:0] w;
        w = {sil, lb, 4'($urandom), 2'(sjw), 1'($urandom), 3'(ts2), 4'(ts1),
             6'($urandom), 10'(brp)};
        cfg_wr_data = w;
        cfg_wr_en = 1'b1;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        c_brp = brp; c_ts1 = ts1; c_ts2 = ts2; c_sjw = sjw; c_lb = lb; c_sil = sil;
        m_valid = 1'b0; tick_seen = 1'b0; tx_seen = 1'b0; exp_rx_pend = 1'b0;
        @(negedge clk);
        chk(cfg_rd_data == (w & 32'hC37F_03FF), "R1", "readback", cfg_rd_data,
            w & 32'hC37F_03FF);
    endtask

    task automatic run_case(input int brp, input int ts1, input int ts2, input int sjw,
                            input bit lb, input bit sil, input int ncyc, input int div);
        @(posedge clk); #1;
        bus_idle = 1'b1; rx_pin = 1'b1; tx_bit = 1'b1;
        write_cfg(brp, ts1, ts2, sjw, lb, sil);
        chk(loopback_mode == lb, "R9", "loopback_mode", loopback_mode, lb);
        chk(silent_mode == sil, "R10", "silent_mode", silent_mode, sil);
        repeat ((brp + 2) * 4) @(posedge clk);
        #1;
        if (lb) tx_bit = 1'b0; else rx_pin = 1'b0;
        repeat ((brp + 1) * 2 + 4) @(posedge clk);
        #1;
        if (!(lb && sil)) chk(m_valid, "R5", "hard sync taken", m_valid, 1);
        bus_idle = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            if ($urandom % div == 0) begin
                if (lb) tx_bit = ~tx_bit; else rx_pin = ~rx_pin;
            end
            if ($urandom % 7 == 0) begin
                if (lb) rx_pin = ~rx_pin; else tx_bit = ~tx_bit;
            end
            @(posedge clk); #1;
        end
        if (lb && sil) begin
            @(negedge clk);
            chk(rx_bit == 1'b1, "R9", "silent loopback rx_bit", rx_bit, 1);
        end
    endtask

    // watchdog ends a hung run as a failure
    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d", wd, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cfg_rd_data == 32'h0, "R1", "reset cfg", cfg_rd_data, 0);
        chk(!sample_pt && !tx_pt, "R12", "reset strobes", {sample_pt, tx_pt}, 0);
        chk(rx_bit == 1'b1, "R11", "reset rx_bit", rx_bit, 1);
        chk(!silent_mode && !loopback_mode, "R1", "reset modes",
            {silent_mode, loopback_mode}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            logic [31:0] w;
            w = $urandom;
            cfg_wr_data = w;
            cfg_wr_en = 1'b1;
            @(posedge clk); #1;
            cfg_wr_en = 1'b0;
            @(negedge clk);
            chk(cfg_rd_data == (w & 32'hC37F_03FF), "R1", "masked word", cfg_rd_data,
                w & 32'hC37F_03FF);
            chk(loopback_mode == w[30], "R9", "mode bit 30", loopback_mode, w[30]);
            chk(silent_mode == w[31], "R10", "mode bit 31", silent_mode, w[31]);
            @(posedge clk); #1;
        end
        run_case(0, 0, 0, 0, 1'b0, 1'b0, 3000, 3);
        run_case(2, 5, 3, 1, 1'b0, 1'b0, 6000, 20);
        run_case(1, 15, 7, 3, 1'b0, 1'b0, 8000, 25);
        run_case(3, 7, 4, 2, 1'b0, 1'b0, 8000, 40);
        run_case(0, 2, 1, 3, 1'b0, 1'b0, 4000, 2);
        for (int k = 0; k < 3; k++)
            run_case(int'($urandom % 6), int'($urandom % 16), int'($urandom % 8),
                     int'($urandom % 4), 1'b0, 1'b0, 6000, 30);
        run_case(1, 4, 3, 1, 1'b1, 1'b0, 5000, 15);
        run_case(1, 4, 3, 1, 1'b0, 1'b1, 4000, 15);
        run_case(0, 3, 2, 0, 1'b1, 1'b1, 2000, 5);
        run_case(2, 6, 5, 2, 1'b0, 1'b0, 3000, 1000000);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule